// File: doc/BRIEF.md
# Extended VGA Bank-Select Register Unit

This unit holds the extended sequencer and graphics-controller registers of an SVGA display controller. From them it derives two 5-bit numbers, one for reads and one for writes, that select a 64 KB window of display memory. The host reaches it through an 8-bit I/O port interface: a 16-bit port address, write data, a write strobe, a read strobe and combinational read data. Each strobe lasts one clock cycle. A write takes effect at the next rising edge. Read data is valid during the cycle in which the read strobe is high.

There are three ways to set the banks: the sequencer extended-control register, the graphics-controller page register, and two direct page ports. The graphics-controller source register decides which of them drive each bank. A read of the chip identification index switches the unit between two register sets, which shows or hides a pair of older shadow control registers. The miscellaneous-output register selects mono or colour addressing. In mono mode, the 0x3Bx and 0x3Dx port blocks swap places.

Top module: `xvga_bank_regs`

## Requirements
- R1: After reset, both bank outputs are 0, the unit is in the new register set, and every readable register reads 0x00.
- R2: While bit 0 of the miscellaneous register (written at 0x3C2, read at 0x3CC) is 0, port addresses 0x3B0–0x3BF and 0x3D0–0x3DF are XORed with 0x60 before decoding. When the bit is 1, no remapping occurs.
- R3: Reading sequencer data (0x3C5) at index 0xB returns 0x33 and selects the new register set. Writing index 0xB selects the old register set.
- R4: In the old set, sequencer indices 0xD and 0xE write and read back two private shadow registers and leave both banks unchanged.
- R5: In the new set, index 0xD writes and reads back its own control register, distinct from the old-set shadow at the same index.
- R6: In the new set, a write to sequencer index 0xE stores data XOR 0x02. The write bank becomes the stored low nibble. The read bank also takes that nibble when graphics register 0xF bit 0 is 0.
- R7: A write to sequencer index 0xC is taken only while the stored sequencer 0xE value has bit 7 set. Otherwise the write is dropped.
- R8: A write to graphics index 0xE (0x3CE/0x3CF) stores data XOR 0x02. When graphics 0xF bit 0 is 1, the read bank becomes the stored low nibble.
- R9: A write to graphics index 0xF stores the value. The read bank then comes from the graphics 0xE nibble if bit 0 is 1, or from the sequencer 0xE nibble if bit 0 is 0. The write bank reloads from the sequencer 0xE nibble.
- R10: Port 0x3D8 always stores and reads back its value. When graphics 0xF bit 2 is 1, the write bank takes data[4:0]. The read bank also takes data[4:0] when graphics 0xF bit 0 is 0.
- R11: Port 0x3D9 always stores and reads back its value. The read bank takes data[4:0] only when graphics 0xF bits 0 and 2 are both 1. The write bank is never changed by this port.
- R12: The index ports (0x3C4, 0x3CE) keep 4 bits and read back with zeros above. Sequencer indices 0–4 and graphics indices 0–8 are plain storage. All other indices and ports read 0x00.
- R13: Reads have no side effects except the identification read in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | Host I/O port address |
| io_wdata | input | 8 | Host write data |
| io_wr | input | 1 | One-cycle write strobe |
| io_rd | input | 1 | One-cycle read strobe |
| io_rdata | output | 8 | Read data for the current address |
| rd_bank | output | 5 | 64 KB bank number used for memory reads |
| wr_bank | output | 5 | 64 KB bank number used for memory writes |

## Verification
The hardest state to reach is the combination of conditions under which a bank source is used. Examples are a direct-port write arriving while the unit is still in mono addressing, or an old-set shadow write that must leave the banks alone. The stimulus therefore starts with the miscellaneous register still at its reset value and reaches the page port only through its aliased address. It then switches to colour addressing, enters the old set with an index-0xB write, and leaves it again with the identification read. A long random phase then interleaves mode switches, index writes and source-select changes, while a behavioural model tracks both banks every clock.

// File: rtl/xvga_bank_pkg.sv
package xvga_bank_pkg;
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int IDX_W     = 4;
    localparam int BANK_W    = 5;
    localparam int SEQ_STD_N = 5;
    localparam int GDC_STD_N = 9;

    localparam logic [ADDR_W-1:0] P_MISC_WR = 16'h03C2;
    localparam logic [ADDR_W-1:0] P_SEQ_IDX = 16'h03C4;
    localparam logic [ADDR_W-1:0] P_SEQ_DAT = 16'h03C5;
    localparam logic [ADDR_W-1:0] P_MISC_RD = 16'h03CC;
    localparam logic [ADDR_W-1:0] P_GDC_IDX = 16'h03CE;
    localparam logic [ADDR_W-1:0] P_GDC_DAT = 16'h03CF;
    localparam logic [ADDR_W-1:0] P_PAGE_A  = 16'h03D8;
    localparam logic [ADDR_W-1:0] P_PAGE_B  = 16'h03D9;

    localparam logic [IDX_W-1:0] X_ID    = 4'hB;
    localparam logic [IDX_W-1:0] X_GATED = 4'hC;
    localparam logic [IDX_W-1:0] X_CTLB  = 4'hD;
    localparam logic [IDX_W-1:0] X_CTLA  = 4'hE;
    localparam logic [IDX_W-1:0] X_SRC   = 4'hF;

    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        byte_t                          misc;
        logic [IDX_W-1:0]               seq_idx;
        logic [IDX_W-1:0]               gdc_idx;
        logic [SEQ_STD_N-1:0][DATA_W-1:0] seq_std;
        logic [GDC_STD_N-1:0][DATA_W-1:0] gdc_std;
        byte_t                          seq_gated;
        byte_t                          seq_ctla;
        byte_t                          old_ctla;
        byte_t                          old_ctlb;
        byte_t                          new_ctlb;
        byte_t                          gdc_page;
        byte_t                          gdc_src;
        byte_t                          page_a;
        byte_t                          page_b;
        logic                           old_set;
        logic [BANK_W-1:0]              rd_bank;
        logic [BANK_W-1:0]              wr_bank;
    } regs_t;
endpackage

// File: rtl/xvga_port_alias.sv
module xvga_port_alias
    import xvga_bank_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr_in,
    input  logic          colour,
    output logic [AW-1:0] addr_out
);
    localparam logic [AW-5:0] BLK_MONO = (AW-4)'(12'h03B);
    localparam logic [AW-5:0] BLK_COL  = (AW-4)'(12'h03D);
    localparam logic [AW-1:0] FLIP     = AW'(16'h0060);

    logic in_block;

    always_comb begin
        in_block = (addr_in[AW-1:4] == BLK_MONO) || (addr_in[AW-1:4] == BLK_COL);
        addr_out = (in_block && !colour) ? (addr_in ^ FLIP) : addr_in;
    end
endmodule

// File: rtl/xvga_rd_mux.sv
module xvga_rd_mux
    import xvga_bank_pkg::*;
#(
    parameter byte_t CHIP_ID = 8'h33
) (
    input  logic [ADDR_W-1:0]             addr,
    input  byte_t                         misc,
    input  logic [IDX_W-1:0]              seq_idx,
    input  logic [IDX_W-1:0]              gdc_idx,
    input  logic [SEQ_STD_N-1:0][DATA_W-1:0] seq_std,
    input  logic [GDC_STD_N-1:0][DATA_W-1:0] gdc_std,
    input  byte_t                         seq_gated,
    input  byte_t                         seq_ctla,
    input  byte_t                         old_ctla,
    input  byte_t                         old_ctlb,
    input  byte_t                         new_ctlb,
    input  byte_t                         gdc_page,
    input  byte_t                         gdc_src,
    input  byte_t                         page_a,
    input  byte_t                         page_b,
    input  logic                          old_set,
    output byte_t                         rdata
);
    byte_t seq_val, gdc_val;

    always_comb begin
        seq_val = '0;
        case (seq_idx)
            X_ID:    seq_val = CHIP_ID;
            X_GATED: seq_val = seq_gated;
            X_CTLB:  seq_val = old_set ? old_ctlb : new_ctlb;
            X_CTLA:  seq_val = old_set ? old_ctla : seq_ctla;
            default: begin
                for (int i = 0; i < SEQ_STD_N; i++)
                    if (seq_idx == IDX_W'(i)) seq_val = seq_std[i];
            end
        endcase

        gdc_val = '0;
        case (gdc_idx)
            X_CTLA:  gdc_val = gdc_page;
            X_SRC:   gdc_val = gdc_src;
            default: begin
                for (int i = 0; i < GDC_STD_N; i++)
                    if (gdc_idx == IDX_W'(i)) gdc_val = gdc_std[i];
            end
        endcase

        case (addr)
            P_MISC_RD: rdata = misc;
            P_SEQ_IDX: rdata = DATA_W'(seq_idx);
            P_SEQ_DAT: rdata = seq_val;
            P_GDC_IDX: rdata = DATA_W'(gdc_idx);
            P_GDC_DAT: rdata = gdc_val;
            P_PAGE_A:  rdata = page_a;
            P_PAGE_B:  rdata = page_b;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/xvga_bank_regs.sv
module xvga_bank_regs
    import xvga_bank_pkg::*;
#(
    parameter byte_t CHIP_ID = 8'h33
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [DATA_W-1:0] io_rdata,
    output logic [BANK_W-1:0] rd_bank,
    output logic [BANK_W-1:0] wr_bank
);
    localparam byte_t INV_MASK = 8'h02;

    regs_t             q, d;
    logic [ADDR_W-1:0] dec_addr;
    byte_t             xor_wdata;
    logic              seq_dat_wr, gdc_dat_wr, seq_dat_rd;

    xvga_port_alias #(.AW(ADDR_W)) alias_i (
        .addr_in  (io_addr),
        .colour   (q.misc[0]),
        .addr_out (dec_addr)
    );

    xvga_rd_mux #(.CHIP_ID(CHIP_ID)) rdmux_i (
        .addr      (dec_addr),
        .misc      (q.misc),
        .seq_idx   (q.seq_idx),
        .gdc_idx   (q.gdc_idx),
        .seq_std   (q.seq_std),
        .gdc_std   (q.gdc_std),
        .seq_gated (q.seq_gated),
        .seq_ctla  (q.seq_ctla),
        .old_ctla  (q.old_ctla),
        .old_ctlb  (q.old_ctlb),
        .new_ctlb  (q.new_ctlb),
        .gdc_page  (q.gdc_page),
        .gdc_src   (q.gdc_src),
        .page_a    (q.page_a),
        .page_b    (q.page_b),
        .old_set   (q.old_set),
        .rdata     (io_rdata)
    );

    always_comb begin
        seq_dat_wr = io_wr && (dec_addr == P_SEQ_DAT);
        gdc_dat_wr = io_wr && (dec_addr == P_GDC_DAT);
        seq_dat_rd = io_rd && (dec_addr == P_SEQ_DAT);
        xor_wdata  = io_wdata ^ INV_MASK;
    end

    always_comb begin
        d = q;
        if (io_wr) begin
            case (dec_addr)
                P_MISC_WR: d.misc    = io_wdata;
                P_SEQ_IDX: d.seq_idx = io_wdata[IDX_W-1:0];
                P_GDC_IDX: d.gdc_idx = io_wdata[IDX_W-1:0];
                P_SEQ_DAT: begin
                    case (q.seq_idx)
                        X_ID:    d.old_set = 1'b1;
                        X_GATED: if (q.seq_ctla[7]) d.seq_gated = io_wdata;
                        X_CTLB: begin
                            if (q.old_set) d.old_ctlb = io_wdata;
                            else           d.new_ctlb = io_wdata;
                        end
                        X_CTLA: begin
                            if (q.old_set) begin
                                d.old_ctla = io_wdata;
                            end else begin
                                d.seq_ctla = xor_wdata;
                                d.wr_bank  = BANK_W'(xor_wdata[3:0]);
                                if (!q.gdc_src[0]) d.rd_bank = BANK_W'(xor_wdata[3:0]);
                            end
                        end
                        default: begin
                            for (int i = 0; i < SEQ_STD_N; i++)
                                if (q.seq_idx == IDX_W'(i)) d.seq_std[i] = io_wdata;
                        end
                    endcase
                end
                P_GDC_DAT: begin
                    case (q.gdc_idx)
                        X_CTLA: begin
                            d.gdc_page = xor_wdata;
                            if (q.gdc_src[0]) d.rd_bank = BANK_W'(xor_wdata[3:0]);
                        end
                        X_SRC: begin
                            d.gdc_src = io_wdata;
                            d.rd_bank = io_wdata[0] ? BANK_W'(q.gdc_page[3:0])
                                                    : BANK_W'(q.seq_ctla[3:0]);
                            d.wr_bank = BANK_W'(q.seq_ctla[3:0]);
                        end
                        default: begin
                            for (int i = 0; i < GDC_STD_N; i++)
                                if (q.gdc_idx == IDX_W'(i)) d.gdc_std[i] = io_wdata;
                        end
                    endcase
                end
                P_PAGE_A: begin
                    d.page_a = io_wdata;
                    if (q.gdc_src[2]) begin
                        d.wr_bank = io_wdata[BANK_W-1:0];
                        if (!q.gdc_src[0]) d.rd_bank = io_wdata[BANK_W-1:0];
                    end
                end
                P_PAGE_B: begin
                    d.page_b = io_wdata;
                    if (q.gdc_src[0] && q.gdc_src[2]) d.rd_bank = io_wdata[BANK_W-1:0];
                end
                default: ;
            endcase
        end
        if (seq_dat_rd && (q.seq_idx == X_ID)) d.old_set = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_bank = q.rd_bank;
    assign wr_bank = q.wr_bank;

    // R3
    id_read_newset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_dat_rd && !io_wr && q.seq_idx == X_ID) |=> !q.old_set)
        else $error("identification read did not select new set");

    // R3
    id_write_oldset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_dat_wr && !io_rd && q.seq_idx == X_ID) |=> q.old_set)
        else $error("index 0xB write did not select old set");

    // R4
    old_shadow_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_dat_wr && q.old_set && q.seq_idx == X_CTLA) |=> ($stable(rd_bank) && $stable(wr_bank)))
        else $error("old-set shadow write moved a bank");

    // R7
    gated_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_dat_wr && q.seq_idx == X_GATED && !q.seq_ctla[7]) |=> $stable(q.seq_gated))
        else $error("gated register written while locked");

    // R9
    src_write_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gdc_dat_wr && q.gdc_idx == X_SRC) |=> (wr_bank == BANK_W'($past(q.seq_ctla[3:0]))))
        else $error("source write did not reload write bank");

    // R11
    page_b_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && dec_addr == P_PAGE_B) |=> $stable(wr_bank))
        else $error("second page port moved write bank");

    // R13
    read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr) |=> ($stable(rd_bank) && $stable(wr_bank)))
        else $error("read changed a bank");
endmodule

// File: tb/xvga_bank_regs_tb.sv
module xvga_bank_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic [4:0]  rd_bank, wr_bank;

    always #2.5 clk = ~clk;

    xvga_bank_regs dut_i (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
        .rd_bank(rd_bank), .wr_bank(wr_bank)
    );

    int    n_cmp = 0, n_bad = 0;
    bit    done = 0, cmp_on = 0;
    string last_tag = "R1";

    // behavioural reference model
    int m_misc, m_sidx, m_gidx, m_old;
    int m_seq[16];
    int m_gdc[16];
    int m_oa, m_ob, m_nb, m_pa, m_pb, m_rb, m_wb;

    function automatic void m_reset();
        m_misc = 0; m_sidx = 0; m_gidx = 0; m_old = 0;
        foreach (m_seq[i]) m_seq[i] = 0;
        foreach (m_gdc[i]) m_gdc[i] = 0;
        m_oa = 0; m_ob = 0; m_nb = 0; m_pa = 0; m_pb = 0; m_rb = 0; m_wb = 0;
    endfunction

    function automatic int m_map(int a);
        if ((m_misc % 2) == 0 && ((a / 16) == 'h3B || (a / 16) == 'h3D)) return a ^ 'h60;
        return a;
    endfunction

    function automatic void m_write(int a0, int v);
        int a = m_map(a0);
        int sv = v ^ 2;
        if (a == 'h3C2) m_misc = v;
        else if (a == 'h3C4) m_sidx = v % 16;
        else if (a == 'h3CE) m_gidx = v % 16;
        else if (a == 'h3C5) begin
            if (m_sidx == 11) m_old = 1;
            else if (m_sidx == 12) begin if (m_seq[14] >= 128) m_seq[12] = v; end
            else if (m_sidx == 13) begin if (m_old) m_ob = v; else m_nb = v; end
            else if (m_sidx == 14) begin
                if (m_old) m_oa = v;
                else begin
                    m_seq[14] = sv; m_wb = sv % 16;
                    if ((m_gdc[15] & 1) == 0) m_rb = sv % 16;
                end
            end else if (m_sidx < 5) m_seq[m_sidx] = v;
        end else if (a == 'h3CF) begin
            if (m_gidx == 14) begin
                m_gdc[14] = sv;
                if (m_gdc[15] & 1) m_rb = sv % 16;
            end else if (m_gidx == 15) begin
                m_gdc[15] = v;
                m_rb = (v & 1) ? m_gdc[14] % 16 : m_seq[14] % 16;
                m_wb = m_seq[14] % 16;
            end else if (m_gidx < 9) m_gdc[m_gidx] = v;
        end else if (a == 'h3D8) begin
            m_pa = v;
            if (m_gdc[15] & 4) begin
                m_wb = v % 32;
                if ((m_gdc[15] & 1) == 0) m_rb = v % 32;
            end
        end else if (a == 'h3D9) begin
            m_pb = v;
            if ((m_gdc[15] & 5) == 5) m_rb = v % 32;
        end
    endfunction

    function automatic int m_read(int a0);
        int a = m_map(a0);
        if (a == 'h3CC) return m_misc;
        if (a == 'h3C4) return m_sidx;
        if (a == 'h3CE) return m_gidx;
        if (a == 'h3D8) return m_pa;
        if (a == 'h3D9) return m_pb;
        if (a == 'h3C5) begin
            if (m_sidx == 11) return 'h33;
            if (m_sidx == 13) return m_old ? m_ob : m_nb;
            if (m_sidx == 14) return m_old ? m_oa : m_seq[14];
            if (m_sidx == 12 || m_sidx < 5) return m_seq[m_sidx];
            return 0;
        end
        if (a == 'h3CF) begin
            if (m_gidx >= 14 || m_gidx < 9) return m_gdc[m_gidx];
            return 0;
        end
        return 0;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // banks compared against the model on every clock
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            check({last_tag, " rd_bank"}, int'(rd_bank), m_rb);
            check({last_tag, " wr_bank"}, int'(wr_bank), m_wb);
        end
    end

    task automatic wr(int a, int v, string tag);
        @(negedge clk);
        io_addr = 16'(a); io_wdata = 8'(v); io_wr = 1'b1; last_tag = tag;
        @(posedge clk); #1;
        m_write(a, v);
        io_wr = 1'b0;
    endtask

    task automatic rd(int a, string tag);
        @(negedge clk);
        io_addr = 16'(a); io_rd = 1'b1; last_tag = tag;
        #1 check({tag, " rdata"}, int'(io_rdata), m_read(a));
        @(posedge clk); #1;
        if (m_map(a) == 'h3C5 && m_sidx == 11) m_old = 0;
        io_rd = 1'b0;
    endtask

    task automatic rd_exp(int a, int exp, string tag);
        @(negedge clk);
        io_addr = 16'(a); io_rd = 1'b1; last_tag = tag;
        #1 check({tag, " rdata"}, int'(io_rdata), exp);
        @(posedge clk); #1;
        if (m_map(a) == 'h3C5 && m_sidx == 11) m_old = 0;
        io_rd = 1'b0;
    endtask

    task automatic banks(int erb, int ewb, string tag);
        @(negedge clk); #1;
        check({tag, " rd_bank lit"}, int'(rd_bank), erb);
        check({tag, " wr_bank lit"}, int'(wr_bank), ewb);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int ports[11] = '{'h3C2, 'h3CC, 'h3C4, 'h3C5, 'h3CE, 'h3CF, 'h3D8, 'h3D9, 'h3B8, 'h3B9, 'h3C0};
        m_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cmp_on = 1;
        // R1 reset state
        banks(0, 0, "R1");
        rd_exp('h3CC, 0, "R1");
        rd_exp('h3C5, 0, "R1");
        rd_exp('h3B8, 0, "R1");
        // R2 mono aliasing: 0x3D8 goes nowhere, 0x3B8 reaches the page port
        wr('h3D8, 'h15, "R2");
        banks(0, 0, "R2");
        wr('h3CE, 'hF, "R2");
        wr('h3CF, 'h04, "R2");
        wr('h3B8, 'h13, "R2");
        banks('h13, 'h13, "R2");
        rd_exp('h3B8, 'h13, "R2");
        rd_exp('h3D8, 0, "R2");
        wr('h3C2, 'h01, "R2");
        rd_exp('h3D8, 'h13, "R10");
        rd_exp('h3B8, 0, "R2");
        // R3 identification and set switching
        wr('h3C4, 'hB, "R3");
        rd_exp('h3C5, 'h33, "R3");
        wr('h3C5, 0, "R3");
        // R4 old-set shadows
        wr('h3C4, 'hD, "R4");
        wr('h3C5, 'h5A, "R4");
        wr('h3C4, 'hE, "R4");
        wr('h3C5, 'hA7, "R4");
        banks('h13, 'h13, "R4");
        rd_exp('h3C5, 'hA7, "R4");
        wr('h3C4, 'hD, "R4");
        rd_exp('h3C5, 'h5A, "R4");
        // R13 repeated reads change nothing
        rd_exp('h3C5, 'h5A, "R13");
        banks('h13, 'h13, "R13");
        // R5 new-set control distinct from old shadow
        wr('h3C4, 'hB, "R3");
        rd_exp('h3C5, 'h33, "R3");
        wr('h3C4, 'hD, "R5");
        rd_exp('h3C5, 0, "R5");
        wr('h3C5, 'h3C, "R5");
        rd_exp('h3C5, 'h3C, "R5");
        wr('h3C4, 'hB, "R5");
        wr('h3C5, 0, "R5");
        wr('h3C4, 'hD, "R5");
        rd_exp('h3C5, 'h5A, "R5");
        wr('h3C4, 'hB, "R5");
        rd_exp('h3C5, 'h33, "R5");
        // R6 inverted bit and write/read bank
        wr('h3C4, 'hE, "R6");
        wr('h3C5, 'h07, "R6");
        banks(5, 5, "R6");
        rd_exp('h3C5, 'h05, "R6");
        // R7 gated index
        wr('h3C4, 'hC, "R7");
        wr('h3C5, 'h99, "R7");
        rd_exp('h3C5, 0, "R7");
        wr('h3C4, 'hE, "R7");
        wr('h3C5, 'h80, "R7");
        banks(2, 2, "R7");
        wr('h3C4, 'hC, "R7");
        wr('h3C5, 'h99, "R7");
        rd_exp('h3C5, 'h99, "R7");
        // R8 graphics page with source bit clear
        wr('h3CE, 'hE, "R8");
        wr('h3CF, 'h0B, "R8");
        banks(2, 2, "R8");
        rd_exp('h3CF, 'h09, "R8");
        // R9 source select
        wr('h3CE, 'hF, "R9");
        wr('h3CF, 'h01, "R9");
        banks(9, 2, "R9");
        wr('h3CE, 'hE, "R8");
        wr('h3CF, 'h0C, "R8");
        banks('hE, 2, "R8");
        wr('h3C4, 'hE, "R6");
        wr('h3C5, 'h86, "R6");
        banks('hE, 4, "R6");
        // R10 first page port
        wr('h3D8, 'h1F, "R10");
        banks('hE, 4, "R10");
        rd_exp('h3D8, 'h1F, "R10");
        wr('h3CE, 'hF, "R9");
        wr('h3CF, 'h05, "R9");
        banks('hE, 4, "R9");
        wr('h3D8, 'h1B, "R10");
        banks('hE, 'h1B, "R10");
        // R11 second page port
        wr('h3D9, 'h17, "R11");
        banks('h17, 'h1B, "R11");
        wr('h3CF, 'h04, "R9");
        banks(4, 4, "R9");
        wr('h3D9, 'h11, "R11");
        banks(4, 4, "R11");
        rd_exp('h3D9, 'h11, "R11");
        wr('h3D8, 'h12, "R10");
        banks('h12, 'h12, "R10");
        // R12 storage and unimplemented indices
        wr('h3C4, 'h17, "R12");
        rd_exp('h3C4, 'h07, "R12");
        wr('h3C5, 'hAA, "R12");
        rd_exp('h3C5, 0, "R12");
        wr('h3CE, 'hA, "R12");
        wr('h3CF, 'h55, "R12");
        rd_exp('h3CF, 0, "R12");
        wr('h3CE, 3, "R12");
        wr('h3CF, 'h66, "R12");
        rd_exp('h3CF, 'h66, "R12");
        wr('h3C4, 2, "R12");
        wr('h3C5, 'h44, "R12");
        rd_exp('h3C5, 'h44, "R12");
        rd_exp('h3C0, 0, "R12");
        // random phase against the model
        for (int n = 0; n < 4000; n++) begin
            int p = ports[$urandom_range(0, 10)];
            int v = int'($urandom_range(0, 255));
            if (p == 'h3C2 && ($urandom_range(0, 3) != 0)) v = v | 1;
            if ($urandom_range(0, 2) == 0) rd(p, "R13");
            else wr(p, v, "R6");
        end
        @(negedge clk);
        cmp_on = 0;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule